// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

A 4-bit counter that has no direction pin. Instead it takes two separate count strobes, one for counting up and one for counting down. The block samples both strobes in its own system clock and acts on their rising edges. An edge on one strobe is counted only while the other strobe is held high. A parameter picks the counting sequence: decade (0 to 9) or full binary (0 to 15).

Two controls override counting. An active-high clear forces the count to zero. An active-low load copies four parallel jam inputs into the count. Clear wins over load. Two active-low terminal outputs mark the ends of the range. Carry goes low at the maximum while the up strobe is low. Borrow goes low at zero while the down strobe is low. Both outputs therefore pulse in step with the active strobe. Wiring carry and borrow to the up and down strobes of a following stage builds a longer counter with no added logic.

The strobes pass through a two-flop synchroniser and then an edge register. A strobe rise therefore changes the count on the third system clock edge after the strobe input changes. The terminal outputs follow the synchronised strobe levels two edges after the strobe input changes.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb` while `dn_stb` is high adds one to `count`. The change appears on the third `clk` edge after the rise. The count wraps from the maximum (9 when `DECADE`=1, 15 when `DECADE`=0) to 0.
- R2: A rising edge on `dn_stb` while `up_stb` is high subtracts one from `count`, with the same latency as R1. The count wraps from 0 to the maximum.
- R3: While `clr` is high, `count` is 0 from the next `clk` edge on, whatever the strobes and `load_n` do.
- R4: While `load_n` is low and `clr` is low, `count` takes the value of `jam` on each `clk` edge, whatever the strobes do.
- R5: `carry_n` is low exactly when `count` equals the maximum and the synchronised `up_stb` is low. Otherwise it is high.
- R6: `borrow_n` is low exactly when `count` is 0 and the synchronised `dn_stb` is low. Otherwise it is high.
- R7: In decade mode, a loaded value from 10 to 15 steps to 0 on an up edge and to 9 on a down edge.
- R8: A strobe edge that arrives while the other strobe is low leaves `count` unchanged. So do two edges that rise in the same cycle.
- R9: Two decade counters chained through carry to up strobe and borrow to down strobe count together as a two-digit decimal counter, in both directions.
- R10: `rst_n` low on a `clk` edge sets `count` to 0 and treats both strobes as idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load enable |
| jam | input | 4 | Parallel load value |
| up_stb | input | 1 | Count-up strobe, acts on rising edge |
| dn_stb | input | 1 | Count-down strobe, acts on rising edge |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal output at maximum |
| borrow_n | output | 1 | Active-low terminal output at zero |

## Verification
Every 4-bit value is loaded into a decade counter and into a binary counter. Each loaded value then receives one up strobe and one down strobe. The two counters differ in their wrap points, and the decade counter must recover from the six illegal values. Each strobe is also pulsed while the other strobe is held low, and both strobes are raised together. This separates a correct interlock from a design that counts on any edge. The terminal outputs are checked at each counter's own maximum and at the other counter's maximum. This shows that the decade and binary limits are decoded separately. A two-digit chain is stepped across the 9/10 boundary upward and back downward.

// File: rtl/updn_pkg.sv
// Package: shared types for the dual-strobe counter.
// Assumes: nothing beyond IEEE 1800-2017.
package updn_pkg;

    // Step requested of the count for one system cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

endpackage

// File: rtl/updn_strobe_sync.sv
// Module: brings one asynchronous strobe into the clk domain and flags
// its rising edges.
// Assumes: the strobe idles high, so every flop resets to 1 and a reset
// never produces a false edge. STAGES must be at least 2.
module updn_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    output logic stb_lvl,
    output logic stb_rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw strobe through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], stb_in};
        end
    end

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign stb_lvl  = chain_q[STAGES-1];
    assign stb_rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/updn_step_logic.sv
// Module: computes the next count for an up or down step, with wrap and
// recovery from values above the maximum.
// Assumes: MAXV fits in WIDTH bits; values above MAXV appear only
// after a load.
module updn_step_logic
    import updn_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int MAXV  = 9
) (
    input  logic [WIDTH-1:0] cur,
    input  step_e            step,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] MAX_L = WIDTH'(MAXV);
    localparam logic [WIDTH-1:0] ONE_L = WIDTH'(1);

    // Select the stepped value for the requested direction
    always_comb begin
        unique case (step)
            STEP_UP: nxt = (cur >= MAX_L) ? '0 : cur + ONE_L;
            STEP_DN: nxt = ((cur == '0) || (cur > MAX_L)) ? MAX_L : cur - ONE_L;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_terminal.sv
// Module: decodes the active-low carry and borrow terminal outputs.
// Assumes: the strobe levels come from the synchronisers, so each pulse
// lasts for the low phase of the synchronised strobe.
module updn_terminal #(
    parameter int WIDTH = 4,
    parameter int MAXV  = 9
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] MAX_L = WIDTH'(MAXV);

    // Gate the end-of-range decodes with the low phase of each strobe
    always_comb begin
        carry_n  = ~((cnt == MAX_L) & ~up_lvl);
        borrow_n = ~((cnt == '0) & ~dn_lvl);
    end

endmodule

// File: rtl/updn_strobe_counter.sv
// Module: top of the dual-strobe presettable up/down counter.
// Assumes: DECADE=1 gives a 0..9 sequence and needs WIDTH >= 4.
// DECADE=0 gives a full 2**WIDTH binary sequence. Clear and load act on
// clk edges; the strobes may be asynchronous to clk.
module updn_strobe_counter
    import updn_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] jam,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam int MAXV = DECADE ? 9 : (2 ** WIDTH) - 1;
    localparam logic [WIDTH-1:0] MAX_L = WIDTH'(MAXV);

    // Index 0 is the up strobe, index 1 the down strobe
    logic [1:0] raw_stb;
    logic [1:0] lvl;
    logic [1:0] rise;

    assign raw_stb = {dn_stb, up_stb};

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_sync
            updn_strobe_sync #(.STAGES(STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .stb_in   (raw_stb[gi]),
                .stb_lvl  (lvl[gi]),
                .stb_rise (rise[gi])
            );
        end
    endgenerate

    step_e            step;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] stepped;

    // Accept an edge only while the opposite strobe is high
    always_comb begin
        if (rise[0] && lvl[1] && !rise[1]) begin
            step = STEP_UP;
        end else if (rise[1] && lvl[0] && !rise[0]) begin
            step = STEP_DN;
        end else begin
            step = STEP_HOLD;
        end
    end

    updn_step_logic #(.WIDTH(WIDTH), .MAXV(MAXV)) u_step (
        .cur  (count_q),
        .step (step),
        .nxt  (stepped)
    );

    // Count register: reset, then clear, then load, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (!load_n) begin
            count_q <= jam;
        end else begin
            count_q <= stepped;
        end
    end

    updn_terminal #(.WIDTH(WIDTH), .MAXV(MAXV)) u_term (
        .cnt      (count_q),
        .up_lvl   (lvl[0]),
        .dn_lvl   (lvl[1]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    assign count = count_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0)); // R3

    AST_LOAD_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (count_q == $past(jam))); // R4

    AST_UP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[0] && lvl[1] && !rise[1]) |=> (count_q != $past(count_q))); // R1

    AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count_q == MAX_L)); // R5

    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count_q == '0)); // R6

    AST_TWO_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[0] && rise[1]) |=> $stable(count_q)); // R8

endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] jam = 4'd0;
    logic       up_stb = 1'b1;
    logic       dn_stb = 1'b1;

    logic [3:0] cnt_d, cnt_b, cnt_h;
    logic       cy_d, bw_d, cy_b, bw_b, cy_h, bw_h;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .jam(jam),
        .up_stb(up_stb), .dn_stb(dn_stb),
        .count(cnt_d), .carry_n(cy_d), .borrow_n(bw_d));

    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b0)) u_bin (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .jam(jam),
        .up_stb(up_stb), .dn_stb(dn_stb),
        .count(cnt_b), .carry_n(cy_b), .borrow_n(bw_b));

    // Upper decade digit, clocked by the terminal outputs of u_dut
    updn_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .jam(jam),
        .up_stb(cy_d), .dn_stb(bw_d),
        .count(cnt_h), .carry_n(cy_h), .borrow_n(bw_h));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int v);
        jam = 4'(v);
        load_n = 1'b0;
        tick(2);
        load_n = 1'b1;
        tick(2);
    endtask

    task automatic up_pulse();
        up_stb = 1'b0;
        tick(4);
        up_stb = 1'b1;
        tick(8);
    endtask

    task automatic dn_pulse();
        dn_stb = 1'b0;
        tick(4);
        dn_stb = 1'b1;
        tick(8);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        check("R10 count after reset", cnt_d, 0);
        check("R10 carry_n after reset", cy_d, 1);
        check("R10 borrow_n after reset", bw_d, 1);

        // Sweep every value: R4 load, R1/R2 steps, R7 decade recovery
        for (int v = 0; v < 16; v++) begin
            load(v);
            check("R4 decade load", cnt_d, v);
            check("R4 binary load", cnt_b, v);
            up_pulse();
            check((v > 9) ? "R7 decade up from illegal" : "R1 decade up", cnt_d, (v >= 9) ? 0 : v + 1);
            check("R1 binary up", cnt_b, (v + 1) % 16);
            load(v);
            dn_pulse();
            check((v > 9) ? "R7 decade down from illegal" : "R2 decade down",
                  cnt_d, (v == 0 || v > 9) ? 9 : v - 1);
            check("R2 binary down", cnt_b, (v + 15) % 16);
        end

        // R8 up edge while down strobe is low
        load(5);
        dn_stb = 1'b0;
        tick(4);
        up_pulse();
        check("R8 up edge with down low", cnt_d, 5);
        dn_stb = 1'b1;
        tick(8);
        check("R8 down release without up low", cnt_d, 4);
        load(5);
        up_stb = 1'b0;
        tick(4);
        dn_pulse();
        check("R8 down edge with up low", cnt_b, 5);
        // Both strobes rise in the same cycle
        dn_stb = 1'b0;
        tick(4);
        up_stb = 1'b1;
        dn_stb = 1'b1;
        tick(8);
        check("R8 simultaneous rise decade", cnt_d, 5);
        check("R8 simultaneous rise binary", cnt_b, 5);

        // R5 carry at each counter's own maximum
        load(9);
        up_stb = 1'b0;
        tick(4);
        check("R5 decade carry_n at 9", cy_d, 0);
        check("R5 binary carry_n at 9", cy_b, 1);
        up_stb = 1'b1;
        tick(1);
        load(9);
        check("R5 decade carry_n up high", cy_d, 1);
        load(15);
        up_stb = 1'b0;
        tick(4);
        check("R5 binary carry_n at 15", cy_b, 0);
        check("R5 decade carry_n at 15", cy_d, 1);
        up_stb = 1'b1;
        tick(8);

        // R6 borrow at zero
        load(0);
        check("R6 borrow_n idle", bw_d, 1);
        dn_stb = 1'b0;
        tick(4);
        check("R6 decade borrow_n at 0", bw_d, 0);
        check("R6 binary borrow_n at 0", bw_b, 0);
        dn_stb = 1'b1;
        tick(8);
        load(1);
        dn_stb = 1'b0;
        tick(4);
        check("R6 borrow_n at 1", bw_d, 1);
        dn_stb = 1'b1;
        tick(8);

        // R3 clear overrides load and strobes
        load(7);
        clr = 1'b1;
        load_n = 1'b0;
        jam = 4'd6;
        tick(2);
        check("R3 clear over load", cnt_d, 0);
        check("R3 clear over load binary", cnt_b, 0);
        up_stb = 1'b0;
        tick(4);
        up_stb = 1'b1;
        tick(8);
        check("R3 clear over up strobe", cnt_d, 0);
        clr = 1'b0;
        load_n = 1'b1;
        tick(2);

        // R9 two-digit chain
        load(0);
        for (int i = 0; i < 10; i++) up_pulse();
        check("R9 chain low digit at 10", cnt_d, 0);
        check("R9 chain high digit at 10", cnt_h, 1);
        for (int i = 0; i < 5; i++) up_pulse();
        check("R9 chain value 15 low", cnt_d, 5);
        check("R9 chain value 15 high", cnt_h, 1);
        for (int i = 0; i < 6; i++) dn_pulse();
        check("R9 chain value 9 low", cnt_d, 9);
        check("R9 chain value 9 high", cnt_h, 0);

        // R10 reset mid-count
        load(6);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R10 count after second reset", cnt_d, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule